// File: doc/BRIEF.md
# Self-Identifying Control and Status Register Bank

This block is the host-facing register bank of a network controller. The host reaches it through a window of 16-bit words addressed by byte offset. Each word it returns names its own register. The six low bits of a word are a fixed identity code. The ten high bits carry the register's flags, configuration or count. Bit 0 of the code tells the two register kinds apart. Codes with bit 0 set belong to read/write configuration registers. Codes with bit 0 clear belong to read-only status registers.

The bank holds a few configuration fields and a transmit-command field. The command field is written at one offset and read back at another. It also presents three live status words and an interrupt-status location that returns the most urgent pending status word. Three 10-bit event counters record missed receive frames, transmit collisions and reflectometer ticks. A counter clears when the host reads it. Read data appears one cycle after the read strobe.

Top module: `netctl_csr_bank`

## Requirements
- R1: After a synchronous reset every configuration field and the command field hold zero and every counter holds zero. A configuration read then returns only its identity code (0x0102→0x0003, 0x0104→0x0005, 0x0106→0x0007, 0x0108→0x0009).
- R2: A write to a configuration offset stores wdata[15:6] only. Bits 5:0 of any readback are always the hardwired code, whatever was written, and the field drives its slice of `ctrl_fields` (offset 0x0102 on bits 9:0, 0x0104 on 19:10, 0x0106 on 29:20).
- R3: Bit 0 of every nonzero read word is 1 for configuration offsets (0x0102–0x0108) and 0 for all others.
- R4: A write at offset 0x0144 updates the command field, which is read at 0x0108 and driven on `tx_cmd_field`. A write at 0x0108 leaves the command field unchanged.
- R5: A read of 0x0144, or of any unmapped or odd offset, returns zero. Writes to status, counter, interrupt-status or unmapped offsets change no state.
- R6: The status words read back the live flag inputs in bits 15:6: receive at 0x0124 (code 0x04), transmit at 0x0128 (code 0x08), link at 0x0134 (code 0x14).
- R7: A read at 0x0120 returns the complete word of the first status word with any flag set, in the order receive, transmit, link. It returns zero when no flag is set.
- R8: Each event input held high for one cycle adds one to its counter. The counters are read at 0x0130 (missed frames, code 0x10), 0x0132 (collisions, code 0x12) and 0x013C (reflectometer, code 0x1C), with the count in bits 15:6.
- R9: A counter read returns the count held before the read edge and clears the counter. An increment in the same cycle as the read leaves the counter at 1.
- R10: A counter at 1023 wraps to 0 on its next increment. On that same edge it raises its `cnt_wrap` bit (0 missed, 1 collision, 2 reflectometer) for exactly one cycle.
- R11: `host_rvalid` is high in the cycle after each read strobe, and only then. `host_rdata` is zero whenever `host_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 12 | Window byte offset |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| stat_rx_flags | input | 10 | Live receive status flags |
| stat_tx_flags | input | 10 | Live transmit status flags |
| stat_line_flags | input | 10 | Live link status flags |
| ev_rx_miss | input | 1 | Missed-frame event |
| ev_tx_col | input | 1 | Collision event |
| ev_tdr_tick | input | 1 | Reflectometer tick |
| ctrl_fields | output | 30 | Configuration fields, register 0 in the low bits |
| tx_cmd_field | output | 10 | Transmit command field |
| cnt_wrap | output | 3 | One-cycle counter wrap pulses |

## Verification
The read path is driven with all-ones, mixed and alternating write patterns. This shows that the stored field and the forced code are kept apart. The interrupt-status location is read with only receive flags set, only transmit flags, only link flags, several at once and none. Each case shows one level of the priority order. The counters are driven with different counts on each input, so crossed counters would show. They are also read on the same cycle as an increment, read twice in a row and run past 1023. These separate clear-on-read ordering from plain counting and from wrapping.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int DATA_W   = 16;
  localparam int CODE_W   = 6;
  localparam int FIELD_W  = DATA_W - CODE_W;
  localparam int ADDR_W   = 12;
  localparam int NUM_STAT = 3;
  localparam int NUM_CNT  = 3;
  localparam int CNT_W    = FIELD_W;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  localparam addr_t A_CTRL_BASE = 12'h102;
  localparam addr_t A_CMD_RD    = 12'h108;
  localparam addr_t A_ISQ       = 12'h120;
  localparam addr_t A_CMD_WR    = 12'h144;
  localparam code_t C_CMD       = 6'h09;

  function automatic addr_t ctrl_addr(int i);
    return A_CTRL_BASE + addr_t'(2 * i);
  endfunction

  function automatic code_t ctrl_code(int i);
    return code_t'(2 * i + 3);
  endfunction

  function automatic addr_t stat_addr(int i);
    case (i)
      0:       return 12'h124;
      1:       return 12'h128;
      default: return 12'h134;
    endcase
  endfunction

  function automatic code_t stat_code(int i);
    case (i)
      0:       return 6'h04;
      1:       return 6'h08;
      default: return 6'h14;
    endcase
  endfunction

  function automatic addr_t cnt_addr(int i);
    case (i)
      0:       return 12'h130;
      1:       return 12'h132;
      default: return 12'h13C;
    endcase
  endfunction

  function automatic code_t cnt_code(int i);
    case (i)
      0:       return 6'h10;
      1:       return 6'h12;
      default: return 6'h1C;
    endcase
  endfunction

  // identity code in the low bits, payload above it
  function automatic word_t pack_word(code_t c, field_t f);
    return {f, c};
  endfunction

  // a clear wins over the old count; a coincident increment still lands
  function automatic cnt_t cnt_next(cnt_t cur, logic inc, logic clr);
    if (clr) return {{(CNT_W-1){1'b0}}, inc};
    return cur + {{(CNT_W-1){1'b0}}, inc};
  endfunction

  function automatic logic is_ctrl_read(addr_t a, int n);
    logic hit;
    hit = (a == A_CMD_RD);
    for (int i = 0; i < n; i++) hit = hit | (a == ctrl_addr(i));
    return hit;
  endfunction
endpackage

// File: rtl/csr_event_counter.sv
module csr_event_counter
  import csr_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output cnt_t count,
  output logic wrap
);
  localparam cnt_t TOP = '1;

  logic at_top;
  assign at_top = (count == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      count <= cnt_next(count, inc, clr);
      wrap  <= inc & ~clr & at_top;
    end
  end

  // R8: plain increment
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !at_top) |=> count == $past(count) + 1'b1);
  // R9: read clears, coincident increment survives
  p_clr_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == {{(CNT_W-1){1'b0}}, $past(inc)});
  // R10: wrap pulse only with a zero count, one cycle wide
  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    wrap |-> count == '0);
  p_wrap_once_r10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
endmodule

// File: rtl/csr_ctrl_file.sv
module csr_ctrl_file
  import csr_bank_pkg::*;
#(
  parameter int NUM_CTRL = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr,
  input  addr_t                            addr,
  input  field_t                           wfield,
  output logic [NUM_CTRL-1:0][FIELD_W-1:0] ctrl_q,
  output field_t                           cmd_q
);
  logic [NUM_CTRL-1:0] ctrl_hit;
  logic                cmd_hit;

  always_comb begin
    for (int i = 0; i < NUM_CTRL; i++) ctrl_hit[i] = wr && (addr == ctrl_addr(i));
  end
  assign cmd_hit = wr && (addr == A_CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (ctrl_hit[i]) ctrl_q[i] <= wfield;
      if (cmd_hit) cmd_q <= wfield;
    end
  end

  // R2: no write, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(ctrl_q) && $stable(cmd_q)));
  // R4: command write lands in the readable copy
  p_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CMD_WR) |=> cmd_q == $past(wfield));
  // R4: the read-only mirror offset does not accept writes
  p_cmd_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CMD_RD) |=> $stable(cmd_q));
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_bank_pkg::*;
#(
  parameter int NUM_CTRL = 3
) (
  input  addr_t                             addr,
  input  logic [NUM_CTRL-1:0][FIELD_W-1:0]  ctrl_q,
  input  field_t                            cmd_q,
  input  logic [NUM_STAT-1:0][FIELD_W-1:0]  stat_flags,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_val,
  output word_t                             rword
);
  word_t isq_word;

  // lowest index with any flag set wins
  always_comb begin
    isq_word = '0;
    for (int i = NUM_STAT - 1; i >= 0; i--)
      if (|stat_flags[i]) isq_word = pack_word(stat_code(i), stat_flags[i]);
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr == ctrl_addr(i)) rword = pack_word(ctrl_code(i), ctrl_q[i]);
    if (addr == A_CMD_RD) rword = pack_word(C_CMD, cmd_q);
    for (int i = 0; i < NUM_STAT; i++)
      if (addr == stat_addr(i)) rword = pack_word(stat_code(i), stat_flags[i]);
    for (int i = 0; i < NUM_CNT; i++)
      if (addr == cnt_addr(i)) rword = pack_word(cnt_code(i), cnt_val[i]);
    if (addr == A_ISQ) rword = isq_word;
  end
endmodule

// File: rtl/netctl_csr_bank.sv
module netctl_csr_bank
  import csr_bank_pkg::*;
#(
  parameter int NUM_CTRL = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic                          host_wr,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic                          host_rd,
  output logic [DATA_W-1:0]             host_rdata,
  output logic                          host_rvalid,
  input  logic [FIELD_W-1:0]            stat_rx_flags,
  input  logic [FIELD_W-1:0]            stat_tx_flags,
  input  logic [FIELD_W-1:0]            stat_line_flags,
  input  logic                          ev_rx_miss,
  input  logic                          ev_tx_col,
  input  logic                          ev_tdr_tick,
  output logic [NUM_CTRL*FIELD_W-1:0]   ctrl_fields,
  output logic [FIELD_W-1:0]            tx_cmd_field,
  output logic [NUM_CNT-1:0]            cnt_wrap
);
  logic [NUM_CTRL-1:0][FIELD_W-1:0] ctrl_q;
  field_t                           cmd_q;
  logic [NUM_STAT-1:0][FIELD_W-1:0] stat_flags;
  logic [NUM_CNT-1:0]               cnt_inc;
  logic [NUM_CNT-1:0]               cnt_clr;
  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_val;
  word_t                            rd_word;
  logic                             rd_is_ctrl;
  logic                             wdata_code_unused;

  assign stat_flags        = {stat_line_flags, stat_tx_flags, stat_rx_flags};
  assign cnt_inc           = {ev_tdr_tick, ev_tx_col, ev_rx_miss};
  assign rd_is_ctrl        = is_ctrl_read(host_addr, NUM_CTRL);
  assign wdata_code_unused = ^host_wdata[CODE_W-1:0];

  csr_ctrl_file #(.NUM_CTRL(NUM_CTRL)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (host_wr),
    .addr   (host_addr),
    .wfield (host_wdata[DATA_W-1:CODE_W]),
    .ctrl_q (ctrl_q),
    .cmd_q  (cmd_q)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_clr[g] = host_rd && (host_addr == cnt_addr(g));
    csr_event_counter u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[g]),
      .clr   (cnt_clr[g]),
      .count (cnt_val[g]),
      .wrap  (cnt_wrap[g])
    );
  end

  csr_read_mux #(.NUM_CTRL(NUM_CTRL)) u_mux (
    .addr       (host_addr),
    .ctrl_q     (ctrl_q),
    .cmd_q      (cmd_q),
    .stat_flags (stat_flags),
    .cnt_val    (cnt_val),
    .rword      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rdata  <= host_rd ? rd_word : '0;
      host_rvalid <= host_rd;
    end
  end

  assign ctrl_fields  = ctrl_q;
  assign tx_cmd_field = cmd_q;

  // R11: read response timing
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !host_rvalid |-> host_rdata == '0);
  // R3: code parity follows the register kind
  p_parity_r3: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && host_rdata != '0) |-> host_rdata[0] == $past(rd_is_ctrl));
  // R5: the write-only command offset reads as zero
  p_cmd_wo_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && $past(host_addr) == A_CMD_WR) |-> host_rdata == '0);
endmodule

// File: tb/netctl_csr_bank_tb.sv
`timescale 1ns/1ps
module netctl_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] host_addr = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic [9:0]  rx_f = '0, tx_f = '0, ln_f = '0;
  logic [2:0]  ev = '0;
  logic [29:0] ctrl_fields;
  logic [9:0]  tx_cmd_field;
  logic [2:0]  cnt_wrap;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  netctl_csr_bank u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .stat_rx_flags(rx_f), .stat_tx_flags(tx_f),
    .stat_line_flags(ln_f), .ev_rx_miss(ev[0]), .ev_tx_col(ev[1]),
    .ev_tdr_tick(ev[2]), .ctrl_fields(ctrl_fields),
    .tx_cmd_field(tx_cmd_field), .cnt_wrap(cnt_wrap)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [5:0] code, input logic [9:0] f);
    return (16'(f) << 6) | 16'(code);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // driver: push the expected word, then strobe the read
  task automatic rd(input logic [11:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      ev[idx] = 1'b1;
      @(negedge clk);
    end
    ev[idx] = 1'b0;
  endtask

  // monitor: pop and compare each returned word
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected rvalid", 32'(host_rdata), 32'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata == e, t, 32'(host_rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_fields == '0, "R1 ctrl_fields", 32'(ctrl_fields), 0);
    chk(tx_cmd_field == '0, "R1 tx_cmd_field", 32'(tx_cmd_field), 0);
    chk(!host_rvalid && host_rdata == 0, "R11 idle", 32'(host_rdata), 0);
    rd(12'h102, 16'h0003, "R1 ctrl0 code");
    rd(12'h104, 16'h0005, "R1 ctrl1 code");
    rd(12'h106, 16'h0007, "R1 ctrl2 code");
    rd(12'h108, 16'h0009, "R1 cmd code");
    rd(12'h130, 16'h0010, "R1 miss zero");
    rd(12'h132, 16'h0012, "R1 col zero");
    rd(12'h13C, 16'h001C, "R1 tdr zero");
    @(negedge clk);
    chk(!host_rvalid && host_rdata == 0, "R11 idle after read", 32'(host_rdata), 0);

    // R2 field vs code
    wr(12'h102, 16'hFFFF);
    wr(12'h104, 16'h1234);
    wr(12'h106, 16'hA5A5);
    rd(12'h102, 16'hFFC3, "R2 all ones");
    rd(12'h104, 16'h1205, "R2 mixed");
    rd(12'h106, 16'hA587, "R2 alternating");
    chk(ctrl_fields == {10'h296, 10'h048, 10'h3FF}, "R2 ctrl_fields", 32'(ctrl_fields), 32'({10'h296, 10'h048, 10'h3FF}));

    // R4 command mirror
    wr(12'h108, 16'hFFC0);
    rd(12'h108, 16'h0009, "R4 write at read copy ignored");
    wr(12'h144, 16'h00C0);
    rd(12'h108, 16'h00C9, "R4 readback of command");
    chk(tx_cmd_field == 10'h003, "R4 tx_cmd_field", 32'(tx_cmd_field), 3);
    rd(12'h144, 16'h0000, "R5 write-only reads zero");
    rd(12'h200, 16'h0000, "R5 unmapped reads zero");
    rd(12'h103, 16'h0000, "R5 odd offset reads zero");

    // R6 live status, R3 parity of status codes
    rx_f = 10'h2AA; tx_f = 10'h3FF; ln_f = 10'h155;
    rd(12'h124, word(6'h04, 10'h2AA), "R6 rx status R3");
    rd(12'h128, word(6'h08, 10'h3FF), "R6 tx status");
    rd(12'h134, word(6'h14, 10'h155), "R6 line status");

    // R7 interrupt status priority
    rd(12'h120, word(6'h04, 10'h2AA), "R7 rx first");
    rx_f = '0;
    rd(12'h120, word(6'h08, 10'h3FF), "R7 tx second");
    tx_f = '0;
    rd(12'h120, word(6'h14, 10'h155), "R7 line last");
    ln_f = '0;
    rd(12'h120, 16'h0000, "R7 none pending");

    // R8 counting, distinct counts per counter
    pulse(0, 5); pulse(1, 7); pulse(2, 3);
    rd(12'h130, word(6'h10, 10'd5), "R8 miss count");
    rd(12'h132, word(6'h12, 10'd7), "R8 col count");
    rd(12'h13C, word(6'h1C, 10'd3), "R8 tdr count");
    rd(12'h130, 16'h0010, "R9 cleared by read");

    // R5 writes to status/counter/isq change nothing
    pulse(0, 2);
    wr(12'h124, 16'hFFFF); wr(12'h130, 16'hFFFF); wr(12'h120, 16'hFFFF);
    rd(12'h130, word(6'h10, 10'd2), "R5 counter write ignored");
    chk(ctrl_fields == {10'h296, 10'h048, 10'h3FF}, "R5 ctrl untouched", 32'(ctrl_fields), 32'({10'h296, 10'h048, 10'h3FF}));
    chk(tx_cmd_field == 10'h003, "R5 cmd untouched", 32'(tx_cmd_field), 3);

    // R9 read coincident with increment
    ev[1] = 1'b1; repeat (3) @(negedge clk);
    rd(12'h132, word(6'h12, 10'd3), "R9 pre-edge value");
    ev[1] = 1'b0;
    rd(12'h132, word(6'h12, 10'd1), "R9 coincident increment kept");

    // R10 wrap
    pulse(2, 1023);
    chk(cnt_wrap == 3'b000, "R10 no pulse at 1023", 32'(cnt_wrap), 0);
    ev[2] = 1'b1; @(negedge clk); ev[2] = 1'b0;
    chk(cnt_wrap == 3'b100, "R10 wrap pulse", 32'(cnt_wrap), 4);
    @(negedge clk);
    chk(cnt_wrap == 3'b000, "R10 pulse one cycle", 32'(cnt_wrap), 0);
    rd(12'h13C, 16'h001C, "R10 wrapped to zero");

    // R1 reset mid-run
    pulse(0, 2);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk(ctrl_fields == '0 && tx_cmd_field == '0, "R1 reset clears fields", 32'(ctrl_fields), 0);
    rd(12'h130, 16'h0010, "R1 reset clears counter");
    rd(12'h102, 16'h0003, "R1 reset ctrl readback");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule